// File: doc/BRIEF.md
# Dual-Channel ATA Task-File Register Block

This block holds the byte-wide command and control registers of two ATA channels, each serving two drive slots. A host bus presents a 16-bit I/O port address with a write strobe or a read strobe. The block decodes that address to one channel and one register, and returns read data in the same cycle as the read strobe. Each drive slot keeps its own sector count, sector number and cylinder bytes. Each channel keeps error, features, drive/head, status, command and device-control registers. The drive-select bit of the drive/head register chooses which slot the per-drive registers address.

The kind of device in each slot is a static configuration input. A slot can hold a disk, an optical drive, or nothing. The block runs the two-step soft reset. Setting the reset bit in device control enters reset, and clearing it leaves reset. Leaving reset loads type-dependent signature values into both slots. When the selected slot is empty, the block masks its registers. Command execution, the 16-bit data port, transfers and interrupts belong to other logic.

Top module: `ata_taskfile`

## Requirements
- R1: Port addresses with (addr & 0xFFF8) equal to 0x1F0 or (addr & 0xFFFE) equal to 0x3F6 belong to channel 0. Addresses 0x170–0x177 and 0x376/0x377 belong to channel 1. `hit` is 1 for offsets 1–7 of the command range and for both control ports. It is 0 for every other address, including the data port at offset 0.
- R2: After `rst_n` the block holds these values: error 0x01, drive/head 0x00, status 0x00, command 0x00, device control 0x08. Every slot holds sector count 0x01, sector number 0x01 and cylinder 0x0000.
- R3: A write to offset 2, 3, 4 or 5 (sector count, sector number, cylinder low, cylinder high) changes only that byte. It changes it only in the slot chosen by bit 4 of the channel's drive/head register.
- R4: A device-control write that moves bit 2 from 0 to 1 sets status to 0x90, error to 0x01 and command to 0x00.
- R5: A device-control write that moves bit 2 from 1 to 0 has these effects. It clears status bit 7, sets status bit 6, and zeroes drive/head bits 3:0. It sets sector count and sector number of both slots to 0x01. It sets the cylinder to 0xEB14 (high 0xEB, low 0x14) for an optical slot and to 0x0000 otherwise. In `drive_cfg`, slot s = 2*channel+drive uses bits [2s+1:2s]: 01 is disk, 10 is optical, and 00 or 11 is absent.
- R6: Every device-control write stores its value. A write that leaves bit 2 unchanged (0→0 or 1→1) changes no other register.
- R7: A drive/head write (offset 6) stores the value with bits 7 and 5 set.
- R8: A drive/head write that selects an absent slot sets error bit 2 and status bit 0.
- R9: A read of offset 1 returns the error register, and a write to offset 1 loads the features register. Reads of offset 7 and of the device-control port return status. A write to offset 7 (command) leaves every readable value unchanged.
- R10: A read of 0x3F7 or 0x377 returns 0xFF.
- R11: While the selected slot is absent, reads of offset 6 return 0xA0. Reads of the other command offsets and of the device-control port return 0x00.
- R12: Writes to unclaimed addresses change nothing. Reads of them return 0x00. `rdata` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset to power-on values |
| addr | input | 16 | I/O port address |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wdata | input | 8 | Write data |
| drive_cfg | input | 8 | Two-bit type code per drive slot |
| rdata | output | 8 | Read data, combinational from address and state |
| hit | output | 1 | Address claimed by the block |

## Verification
The bench builds the block with its default port bases: primary at 0x1F0/0x3F6 and secondary at 0x170/0x376. This lets it check the decode masks against real neighbouring addresses, such as the data port and 0x2F6. It sweeps all 256 drive/head values on a channel with both slots present, and again on a channel with one slot empty. This covers select-driven masking and the abort flags. It also steps through all sixteen type pairs of the secondary channel's two slots, and checks the post-reset cylinder signature of each.

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter logic [15:0] PRI_BASE = 16'h01F0,
  parameter logic [15:0] SEC_BASE = 16'h0170,
  parameter logic [15:0] PRI_CTL  = 16'h03F6,
  parameter logic [15:0] SEC_CTL  = 16'h0376
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  input  logic [7:0]  drive_cfg,
  output logic [7:0]  rdata,
  output logic        hit
);
  localparam int NCH      = 2;
  localparam int NSLOT    = 2 * NCH;
  localparam int SRST_BIT = 2;
  localparam int DSEL_BIT = 4;
  localparam logic [7:0] DH_FORCE = 8'hA0;
  localparam logic [15:0] CMD_MASK = 16'hFFF8;
  localparam logic [15:0] CTL_MASK = 16'hFFFE;

  logic [7:0] err_q  [NCH];
  logic [7:0] feat_q [NCH];
  logic [7:0] dh_q   [NCH];
  logic [7:0] st_q   [NCH];
  logic [7:0] cmd_q  [NCH];
  logic [7:0] ctl_q  [NCH];
  logic [7:0] sc_q   [NSLOT];
  logic [7:0] sn_q   [NSLOT];
  logic [7:0] cl_q   [NSLOT];
  logic [7:0] chi_q  [NSLOT];

  function automatic logic is_present(input logic [1:0] t);
    return (t == 2'b01) || (t == 2'b10);
  endfunction

  logic [1:0] cmd_hit, ctl_hit;
  assign cmd_hit[0] = (addr & CMD_MASK) == PRI_BASE;
  assign cmd_hit[1] = (addr & CMD_MASK) == SEC_BASE;
  assign ctl_hit[0] = (addr & CTL_MASK) == PRI_CTL;
  assign ctl_hit[1] = (addr & CTL_MASK) == SEC_CTL;

  logic       ch, is_cmd, is_ctl, alt, devctl;
  logic [2:0] off;
  assign ch     = ~cmd_hit[0] & ~ctl_hit[0];
  assign is_cmd = |cmd_hit;
  assign is_ctl = |ctl_hit;
  assign off    = addr[2:0];
  assign alt    = is_ctl & addr[0];
  assign devctl = is_ctl & ~addr[0];
  assign hit    = alt | devctl | (is_cmd & (off != 3'd0));

  logic [1:0] slot, wslot;
  logic       cur_present, new_present;
  assign slot        = {ch, dh_q[ch][DSEL_BIT]};
  assign wslot       = {ch, wdata[DSEL_BIT]};
  assign cur_present = is_present(drive_cfg[{slot, 1'b0} +: 2]);
  assign new_present = is_present(drive_cfg[{wslot, 1'b0} +: 2]);

  logic [7:0] rval;
  always_comb begin
    rval = 8'h00;
    if (alt) rval = 8'hFF;
    else if (!cur_present) rval = (is_cmd && off == 3'd6) ? DH_FORCE : 8'h00;
    else if (devctl) rval = st_q[ch];
    else begin
      case (off)
        3'd1: rval = err_q[ch];
        3'd2: rval = sc_q[slot];
        3'd3: rval = sn_q[slot];
        3'd4: rval = cl_q[slot];
        3'd5: rval = chi_q[slot];
        3'd6: rval = dh_q[ch];
        3'd7: rval = st_q[ch];
        default: rval = 8'h00;
      endcase
    end
  end
  assign rdata = (rd_en && hit) ? rval : 8'h00;

  logic [1:0] s0, s1;
  logic       opt0, opt1;
  assign s0   = {ch, 1'b0};
  assign s1   = {ch, 1'b1};
  assign opt0 = drive_cfg[{s0, 1'b0} +: 2] == 2'b10;
  assign opt1 = drive_cfg[{s1, 1'b0} +: 2] == 2'b10;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        err_q[c]  <= 8'h01;
        feat_q[c] <= 8'h00;
        dh_q[c]   <= 8'h00;
        st_q[c]   <= 8'h00;
        cmd_q[c]  <= 8'h00;
        ctl_q[c]  <= 8'h08;
      end
      for (int s = 0; s < NSLOT; s++) begin
        sc_q[s]  <= 8'h01;
        sn_q[s]  <= 8'h01;
        cl_q[s]  <= 8'h00;
        chi_q[s] <= 8'h00;
      end
    end else if (wr_en && hit && !alt) begin
      if (devctl) begin
        if (!ctl_q[ch][SRST_BIT] && wdata[SRST_BIT]) begin
          st_q[ch]  <= 8'h90;
          err_q[ch] <= 8'h01;
          cmd_q[ch] <= 8'h00;
        end else if (ctl_q[ch][SRST_BIT] && !wdata[SRST_BIT]) begin
          st_q[ch]      <= (st_q[ch] & 8'h7F) | 8'h40;
          dh_q[ch][3:0] <= 4'h0;
          sc_q[s0]  <= 8'h01;
          sn_q[s0]  <= 8'h01;
          cl_q[s0]  <= opt0 ? 8'h14 : 8'h00;
          chi_q[s0] <= opt0 ? 8'hEB : 8'h00;
          sc_q[s1]  <= 8'h01;
          sn_q[s1]  <= 8'h01;
          cl_q[s1]  <= opt1 ? 8'h14 : 8'h00;
          chi_q[s1] <= opt1 ? 8'hEB : 8'h00;
        end
        ctl_q[ch] <= wdata;
      end else begin
        case (off)
          3'd1: feat_q[ch]  <= wdata;
          3'd2: sc_q[slot]  <= wdata;
          3'd3: sn_q[slot]  <= wdata;
          3'd4: cl_q[slot]  <= wdata;
          3'd5: chi_q[slot] <= wdata;
          3'd6: begin
            dh_q[ch] <= wdata | DH_FORCE;
            if (!new_present) begin
              err_q[ch] <= err_q[ch] | 8'h04;
              st_q[ch]  <= st_q[ch] | 8'h01;
            end
          end
          3'd7: cmd_q[ch] <= wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r4_reset_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && devctl && ch == c && wdata[SRST_BIT] && !ctl_q[c][SRST_BIT])
      |=> (st_q[c] == 8'h90 && err_q[c] == 8'h01 && cmd_q[c] == 8'h00));
    a_r5_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && devctl && ch == c && !wdata[SRST_BIT] && ctl_q[c][SRST_BIT])
      |=> (!st_q[c][7] && st_q[c][6] && dh_q[c][3:0] == 4'h0));
    a_r6_ctl_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && devctl && ch == c) |=> ctl_q[c] == $past(wdata));
    a_r7_dh_force: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_cmd && ch == c && off == 3'd6) |=> (dh_q[c][7] && dh_q[c][5]));
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_cmd && ch == c && off == 3'd6 && !new_present)
      |=> (err_q[c][2] && st_q[c][0]));
    a_r9_features: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_cmd && ch == c && off == 3'd1) |=> feat_q[c] == $past(wdata));
  end

  a_r10_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && alt) |-> (rdata == 8'hFF && hit));
  a_r11_absent_dh: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_cmd && off == 3'd6 && !cur_present) |-> rdata == DH_FORCE);
  a_r12_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || !hit) |-> rdata == 8'h00);
endmodule

// File: tb/ata_taskfile_test.sv
module ata_taskfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  drive_cfg = 8'b01_00_10_01;
  logic [7:0]  rdata;
  logic        hit;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  ata_taskfile uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
                    .wdata(wdata), .drive_cfg(drive_cfg), .rdata(rdata), .hit(hit));

  always #5 clk = ~clk;

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input logic exp_hit, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1; #1;
    checks++;
    if (rdata !== exp || hit !== exp_hit) begin
      errors++;
      $display("FAIL %s addr=%h rdata=%h hit=%b expected rdata=%h hit=%b", tag, a, rdata, hit, exp, exp_hit);
    end
    rd_en = 1'b0;
  endtask

  initial begin
    do_reset();
    // R2 power-on, R10 alt status, R1 decode
    rd(16'h01F1, 8'h01, 1, "R2 err");
    rd(16'h01F2, 8'h01, 1, "R2 sc");
    rd(16'h01F3, 8'h01, 1, "R2 sn");
    rd(16'h01F4, 8'h00, 1, "R2 cl");
    rd(16'h01F5, 8'h00, 1, "R2 ch");
    rd(16'h01F6, 8'h00, 1, "R2 dh");
    rd(16'h01F7, 8'h00, 1, "R2 status");
    rd(16'h03F6, 8'h00, 1, "R9 ctl status");
    rd(16'h03F7, 8'hFF, 1, "R10 alt pri");
    rd(16'h0377, 8'hFF, 1, "R10 alt sec");
    rd(16'h01F0, 8'h00, 0, "R1 data port");
    rd(16'h02F6, 8'h00, 0, "R1 stray");
    // R11 channel 1 slot 0 absent
    rd(16'h0176, 8'hA0, 1, "R11 dh absent");
    for (int a = 16'h0171; a <= 16'h0177; a++)
      if (a != 16'h0176) rd(a[15:0], 8'h00, 1, "R11 masked");
    rd(16'h0376, 8'h00, 1, "R11 ctl masked");
    // R3 byte-local writes
    wr(16'h01F3, 8'h33);
    rd(16'h01F3, 8'h33, 1, "R3 sn");
    rd(16'h01F4, 8'h00, 1, "R3 cl untouched");
    wr(16'h01F4, 8'h44);
    rd(16'h01F4, 8'h44, 1, "R3 cl");
    rd(16'h01F5, 8'h00, 1, "R3 ch untouched");
    wr(16'h01F5, 8'h55);
    wr(16'h01F2, 8'h22);
    rd(16'h01F5, 8'h55, 1, "R3 ch");
    rd(16'h01F2, 8'h22, 1, "R3 sc");
    // R9 features/error, command
    wr(16'h01F1, 8'hAA);
    rd(16'h01F1, 8'h01, 1, "R9 err not features");
    wr(16'h01F7, 8'hEC);
    rd(16'h01F7, 8'h00, 1, "R9 cmd no effect");
    // R12 unclaimed writes
    wr(16'h01F0, 8'h77);
    wr(16'h02F2, 8'h77);
    rd(16'h01F2, 8'h22, 1, "R12 sc kept");
    rd(16'h01F3, 8'h33, 1, "R12 sn kept");
    // R3/R7 slot select
    wr(16'h01F6, 8'h10);
    rd(16'h01F6, 8'hB0, 1, "R7 dh");
    rd(16'h01F2, 8'h01, 1, "R3 slot1 sc");
    rd(16'h01F4, 8'h00, 1, "R3 slot1 cl");
    wr(16'h01F4, 8'h66);
    wr(16'h01F6, 8'h00);
    rd(16'h01F6, 8'hA0, 1, "R7 dh back");
    rd(16'h01F4, 8'h44, 1, "R3 slot0 kept");
    // R8 absent select on channel 1
    wr(16'h0176, 8'h00);
    wr(16'h0176, 8'h10);
    rd(16'h0176, 8'hB0, 1, "R7 sec dh");
    rd(16'h0171, 8'h05, 1, "R8 abort");
    rd(16'h0177, 8'h01, 1, "R8 status err");
    rd(16'h0376, 8'h01, 1, "R9 ctl status");
    rd(16'h01F7, 8'h00, 1, "R8 pri unaffected");
    // R7 sweeps
    for (int v = 0; v < 256; v++) begin
      wr(16'h01F6, v[7:0]);
      rd(16'h01F6, v[7:0] | 8'hA0, 1, "R7 sweep pri");
    end
    for (int v = 0; v < 256; v++) begin
      wr(16'h0176, v[7:0]);
      rd(16'h0176, v[4] ? (v[7:0] | 8'hA0) : 8'hA0, 1, "R11 sweep sec");
    end
    // R4/R5/R6 soft reset on channel 0 (dh=FF, slot 1 optical)
    wr(16'h03F6, 8'h04);
    rd(16'h01F7, 8'h90, 1, "R4 status");
    rd(16'h01F1, 8'h01, 1, "R4 err");
    rd(16'h0177, 8'h01, 1, "R4 other channel");
    wr(16'h03F6, 8'h06);
    rd(16'h01F7, 8'h90, 1, "R6 1to1");
    wr(16'h03F6, 8'h00);
    rd(16'h01F7, 8'h50, 1, "R5 status");
    rd(16'h01F6, 8'hF0, 1, "R5 head zero");
    rd(16'h01F2, 8'h01, 1, "R5 sc");
    rd(16'h01F3, 8'h01, 1, "R5 sn");
    rd(16'h01F4, 8'h14, 1, "R5 optical low");
    rd(16'h01F5, 8'hEB, 1, "R5 optical high");
    wr(16'h01F6, 8'h00);
    rd(16'h01F4, 8'h00, 1, "R5 disk low");
    rd(16'h01F5, 8'h00, 1, "R5 disk high");
    rd(16'h01F3, 8'h01, 1, "R5 disk sn");
    wr(16'h01F4, 8'h12);
    wr(16'h03F6, 8'h00);
    rd(16'h01F7, 8'h50, 1, "R6 0to0 status");
    rd(16'h01F4, 8'h12, 1, "R6 0to0 slots");
    // R5 signature for all type pairs on channel 1
    for (int t0 = 0; t0 < 4; t0++)
      for (int t1 = 0; t1 < 4; t1++) begin
        drive_cfg = {t1[1:0], t0[1:0], 4'b10_01};
        do_reset();
        wr(16'h0376, 8'h04);
        wr(16'h0376, 8'h00);
        for (int d = 0; d < 2; d++) begin
          automatic int t = d ? t1 : t0;
          automatic bit pres = (t == 1) || (t == 2);
          automatic bit opt = (t == 2);
          wr(16'h0176, d ? 8'h10 : 8'h00);
          rd(16'h0176, pres ? (d ? 8'hB0 : 8'hA0) : 8'hA0, 1, "R11 cfg dh");
          rd(16'h0174, pres ? (opt ? 8'h14 : 8'h00) : 8'h00, 1, "R5 cfg low");
          rd(16'h0175, pres ? (opt ? 8'hEB : 8'h00) : 8'h00, 1, "R5 cfg high");
          rd(16'h0172, pres ? 8'h01 : 8'h00, 1, "R5 cfg sc");
        end
      end
    rd(16'h0170, 8'h00, 0, "R12 sec data port");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule